// File: doc/BRIEF.md
# Steered PWM Output Stage

This block takes one raw PWM waveform, produced by a separate timebase, and spreads it across four output pins. Software picks any subset of the pins to carry the waveform. Each active edge can be held back by a programmable number of instruction cycles, which creates dead time. A two-bit field sets the active level of each pin pair. A per-pin active-low driver enable gates what leaves the block.

A fault input stops the steered pins through a shutdown latch. The fault is first passed through a two-flop synchroniser. Two recovery modes are available. In automatic mode the latch clears as soon as the fault goes away. In software mode the latch holds until a clear strobe arrives. In both modes the waveform comes back only at the next period-start pulse, so a partial pulse never reaches a pin. Pins that are not steered are left out of the shutdown and drive a fixed 0.

Top module: `pwm_steer_stage`

## Requirements
- R1: After reset `shutdown_o` is 0. Every steered pin with its driver enabled drives its inactive level until the first `period_start_i` pulse has been taken.
- R2: With delay value D, the internal active state rises on the clock edge after `pwm_raw_i` has been sampled high through D rising-edge samplings of `icyc_en_i`. With D = 0 it rises at the first edge that samples `pwm_raw_i` high.
- R3: An edge that samples `pwm_raw_i` low makes the active state inactive at once, with no delay.
- R4: A raw pulse that ends before its delay has run out produces no active level on any pin.
- R5: Pin i carries the PWM only when `steer_en_i[i]` is 1. Any combination of the four pins may carry it at the same time.
- R6: Polarity is set per pin pair. `pol_i[1]`=1 makes pins 0 and 2 active-low. `pol_i[0]`=1 makes pins 1 and 3 active-low. The output level is the active state XOR that bit.
- R7: A pin whose steering bit is 0 drives 0, whatever the shutdown, polarity or PWM state.
- R8: `pin_oe_o[i]` is the inverse of `drv_en_ni[i]`. When a driver is disabled, `pin_o[i]` is 0.
- R9: A high `shutdown_evt_i` sets `shutdown_o` on the third clock edge. Steered pins then drive their inactive level.
- R10: With `restart_en_i`=1, `shutdown_o` clears on the edge after the synchronised event has gone low.
- R11: With `restart_en_i`=0, `shutdown_o` stays set until `sd_clear_i` is sampled while the synchronised event is low. A pending set wins over a clear in the same cycle.
- R12: After `shutdown_o` clears, the steered pins stay inactive until the next `period_start_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| icyc_en_i | input | 1 | Instruction-cycle enable, one clock in four |
| pwm_raw_i | input | 1 | Raw PWM from the timebase |
| period_start_i | input | 1 | Period-start pulse |
| delay_cnt_i | input | 7 | Active-edge delay in instruction cycles |
| steer_en_i | input | 4 | Per-pin steering enables |
| pol_i | input | 2 | Pin-pair polarity select |
| restart_en_i | input | 1 | 1 = automatic shutdown recovery |
| shutdown_evt_i | input | 1 | Asynchronous shutdown event |
| sd_clear_i | input | 1 | Software clear strobe for the shutdown flag |
| drv_en_ni | input | 4 | Per-pin driver enable, active low |
| pin_o | output | 4 | Pin levels |
| pin_oe_o | output | 4 | Pin driver enables, active high |
| shutdown_o | output | 1 | Shutdown status flag |

## Verification
The bench targets the following corner cases.

- **Zero delay and counting.** A delay of zero must give a one-clock rise, and a longer delay must count `icyc_en_i` samplings rather than clocks. An off-by-one counter shifts every rising edge, and a counter fed by the clock rises four times too early.
- **Short pulses.** A raw pulse shorter than its delay must produce no output. A design that latches the pending edge would emit a runt pulse.
- **Set against clear.** The bench holds the fault while pulsing the software clear. A design that lets the clear win would show `shutdown_o` flickering low.
- **Resume timing.** Resumption is checked against the period-start pulse. An ungated design would emit a truncated pulse mid-period.
- **Random cross-check.** Random steering, polarity and driver-enable mixes are compared cycle by cycle against a bench model. This catches swapped polarity pairs and shutdown leaking onto unsteered pins.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  typedef logic [1:0] pol_t;

  // even pins follow pol[1], odd pins follow pol[0]
  function automatic logic pol_bit(input pol_t pol, input int idx);
    return (idx % 2 == 0) ? pol[1] : pol[0];
  endfunction
endpackage

// File: rtl/pwm_edge_delay.sv
module pwm_edge_delay #(
  parameter int unsigned DLY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             icyc_en_i,
  input  logic             raw_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             act_o
);
  logic [DLY_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!raw_i) begin
      // falling edge is never delayed
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!act_q) begin
      if (cnt_q == dly_i)  act_q <= 1'b1;
      else if (icyc_en_i)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_sd_latch.sv
module pwm_sd_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_s_i,
  input  logic restart_en_i,
  input  logic sw_clr_i,
  input  logic period_start_i,
  output logic sd_o,
  output logic run_o
);
  logic sd_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (evt_s_i)                       sd_q <= 1'b1;  // set wins
      else if (restart_en_i || sw_clr_i) sd_q <= 1'b0;
      if (sd_q)                          run_q <= 1'b0;
      else if (period_start_i)           run_q <= 1'b1;
    end
  end

  assign sd_o  = sd_q;
  assign run_o = run_q;
endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive (
  input  logic act_i,
  input  logic gate_i,
  input  logic steer_i,
  input  logic inv_i,
  input  logic drv_en_ni,
  output logic pin_o,
  output logic oe_o
);
  logic lvl;

  assign lvl   = steer_i ? ((act_i & gate_i) ^ inv_i) : 1'b0;
  assign oe_o  = ~drv_en_ni;
  assign pin_o = oe_o & lvl;
endmodule

// File: rtl/pwm_steer_stage.sv
module pwm_steer_stage #(
  parameter int unsigned N_PINS = 4,
  parameter int unsigned DLY_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              icyc_en_i,
  input  logic              pwm_raw_i,
  input  logic              period_start_i,
  input  logic [DLY_W-1:0]  delay_cnt_i,
  input  logic [N_PINS-1:0] steer_en_i,
  input  logic [1:0]        pol_i,
  input  logic              restart_en_i,
  input  logic              shutdown_evt_i,
  input  logic              sd_clear_i,
  input  logic [N_PINS-1:0] drv_en_ni,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              shutdown_o
);
  import pwm_steer_pkg::*;

  logic evt_m, evt_s;
  logic act, sd, run, gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_m <= 1'b0;
      evt_s <= 1'b0;
    end else begin
      evt_m <= shutdown_evt_i;
      evt_s <= evt_m;
    end
  end

  pwm_edge_delay #(.DLY_W(DLY_W)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .icyc_en_i(icyc_en_i),
    .raw_i(pwm_raw_i), .dly_i(delay_cnt_i), .act_o(act)
  );

  pwm_sd_latch u_sd (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_s_i(evt_s),
    .restart_en_i(restart_en_i), .sw_clr_i(sd_clear_i),
    .period_start_i(period_start_i), .sd_o(sd), .run_o(run)
  );

  assign gate       = run & ~sd;
  assign shutdown_o = sd;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pwm_pin_drive u_pin (
      .act_i(act), .gate_i(gate), .steer_i(steer_en_i[i]),
      .inv_i(pol_bit(pol_i, i)), .drv_en_ni(drv_en_ni[i]),
      .pin_o(pin_o[i]), .oe_o(pin_oe_o[i])
    );
  end
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
  parameter int unsigned N_PINS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwm_raw_i,
  input logic [N_PINS-1:0] steer_en_i,
  input logic [1:0]        pol_i,
  input logic [N_PINS-1:0] drv_en_ni,
  input logic              restart_en_i,
  input logic              sd_clear_i,
  input logic [N_PINS-1:0] pin_o,
  input logic              shutdown_o,
  input logic              evt_s,
  input logic              act
);
  import pwm_steer_pkg::*;

  logic [N_PINS-1:0] inact;
  always_comb
    for (int i = 0; i < N_PINS; i++) inact[i] = pol_bit(pol_i, i);

  a_r3_fall_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_raw_i |=> !act);
  a_r7_unsteered_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~steer_en_i) == '0);
  a_r8_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & drv_en_ni) == '0);
  a_r9_sd_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_s |=> shutdown_o);
  a_r10_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o && restart_en_i && !evt_s |=> !shutdown_o);
  a_r11_sd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o && !restart_en_i && !sd_clear_i |=> shutdown_o);
  a_r12_sd_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> ((pin_o ^ inact) & steer_en_i & ~drv_en_ni) == '0);
endmodule

bind pwm_steer_stage pwm_steer_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_raw_i(pwm_raw_i),
  .steer_en_i(steer_en_i), .pol_i(pol_i), .drv_en_ni(drv_en_ni),
  .restart_en_i(restart_en_i), .sd_clear_i(sd_clear_i),
  .pin_o(pin_o), .shutdown_o(shutdown_o), .evt_s(evt_s), .act(act)
);

// File: tb/sim_pwm_steer_stage.sv
module sim_pwm_steer_stage;
  logic clk = 1'b0, rst_n = 1'b0;
  logic icyc = 0, raw = 0, pstart = 0, restart = 0, evt = 0, clr = 0;
  logic [6:0] dly = 0;
  logic [3:0] steer = 4'hF, drvn = 4'h0, pin, oe;
  logic [1:0] pol = 0;
  logic sd;

  int tests = 0, fails = 0, icnt = 0;
  bit done = 0;
  string tag = "R1";

  // requirement-derived model state
  logic m_s1, m_s2, m_sd, m_run, m_act;
  int   m_cnt;

  always #10 clk = ~clk;

  pwm_steer_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .icyc_en_i(icyc), .pwm_raw_i(raw),
    .period_start_i(pstart), .delay_cnt_i(dly), .steer_en_i(steer),
    .pol_i(pol), .restart_en_i(restart), .shutdown_evt_i(evt),
    .sd_clear_i(clr), .drv_en_ni(drvn), .pin_o(pin), .pin_oe_o(oe),
    .shutdown_o(sd)
  );

  function automatic logic inv_of(int i);
    return (i % 2 == 0) ? pol[1] : pol[0];
  endfunction

  function automatic logic [3:0] exp_pins();
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = !drvn[i] && steer[i] && ((m_act && m_run && !m_sd) ^ inv_of(i));
    return r;
  endfunction

  task automatic check(string t, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic model_step();
    logic n_sd, n_run, n_act; int n_cnt;
    n_act = m_act; n_cnt = m_cnt;
    if (!raw) begin n_act = 0; n_cnt = 0; end
    else if (!m_act) begin
      if (m_cnt == int'(dly)) n_act = 1;
      else if (icyc) n_cnt = m_cnt + 1;
    end
    n_sd = m_s2 ? 1'b1 : ((restart || clr) ? 1'b0 : m_sd);
    n_run = m_sd ? 1'b0 : (pstart ? 1'b1 : m_run);
    m_s2 = m_s1; m_s1 = evt;
    m_sd = n_sd; m_run = n_run; m_act = n_act; m_cnt = n_cnt;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, {4'h0, pin}, {4'h0, exp_pins()});
    check("R8", {4'h0, oe}, {4'h0, ~drvn});
    check("R9", {7'h0, sd}, {7'h0, m_sd});
    icnt++;
    icyc = (icnt % 4 == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    void'($urandom(32'd1234));
    {m_s1, m_s2, m_sd, m_run, m_act} = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {3'h0, sd, pin}, 8'h00);
    pol = 2'b11;
    #1 check("R1", {4'h0, pin}, 8'h0F);
    pol = 2'b00;
    rst_n = 1'b1;
    raw = 1; repeat (3) tick();
    check("R1", {4'h0, pin}, 8'h00);  // not yet running
    raw = 0; pstart = 1; tick(); pstart = 0; tick();

    // R2: zero delay gives one-clock rise
    tag = "R2"; dly = 0; raw = 1; tick();
    check("R2", {4'h0, pin}, 8'h0F);
    // R3: immediate fall
    tag = "R3"; raw = 0; tick();
    check("R3", {4'h0, pin}, 8'h00);
    // R2: longer delay counted in instruction cycles
    tag = "R2"; dly = 3; raw = 1;
    for (int k = 0; k < 20; k++) tick();
    check("R2", {4'h0, pin}, 8'h0F);
    raw = 0; tick();
    // R4: short pulse suppressed
    tag = "R4"; dly = 20; raw = 1; seen = 0;
    for (int k = 0; k < 40; k++) begin tick(); if (pin != 0) seen = 1; end
    raw = 0; tick();
    check("R4", 8'(seen), 8'h00);
    // R5/R6/R7: steering subset and polarity
    tag = "R5"; dly = 0; steer = 4'b0101; pol = 2'b01; raw = 1; tick();
    check("R5", {4'h0, pin}, 8'h05);
    tag = "R6"; raw = 0; tick();
    check("R6", {4'h0, pin}, 8'h00);
    steer = 4'b1010; tick();
    check("R6", {4'h0, pin}, 8'h0A);
    tag = "R7"; steer = 4'b0000; tick();
    check("R7", {4'h0, pin}, 8'h00);
    steer = 4'hF; pol = 0;
    // R11: set wins over clear; held without restart
    tag = "R11"; restart = 0; raw = 1; evt = 1; clr = 1;
    for (int k = 0; k < 6; k++) tick();
    check("R11", {7'h0, sd}, 8'h01);
    evt = 0; clr = 0;
    for (int k = 0; k < 6; k++) tick();
    check("R11", {7'h0, sd}, 8'h01);
    clr = 1; tick(); clr = 0; tick();
    check("R11", {7'h0, sd}, 8'h00);
    // R12: resume only at period start
    tag = "R12"; tick();
    check("R12", {4'h0, pin}, 8'h00);
    pstart = 1; tick(); pstart = 0; tick();
    check("R12", {4'h0, pin}, 8'h0F);
    // R10: automatic restart
    tag = "R10"; restart = 1; evt = 1; repeat (4) tick();
    check("R10", {7'h0, sd}, 8'h01);
    evt = 0; repeat (3) tick();
    check("R10", {7'h0, sd}, 8'h00);

    // randomised cross-check against the model
    tag = "R5";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 9) == 0) raw = ~raw;
      pstart = ($urandom_range(0, 24) == 0);
      if ($urandom_range(0, 59) == 0) evt = ~evt;
      clr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 99) == 0) restart = ~restart;
      if ($urandom_range(0, 199) == 0) steer = 4'($urandom);
      if ($urandom_range(0, 199) == 0) pol = 2'($urandom);
      if ($urandom_range(0, 199) == 0) drvn = 4'($urandom);
      if ($urandom_range(0, 149) == 0) dly = 7'($urandom_range(0, 6));
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule